// File: doc/BRIEF.md
# Bridge I/O Space Claim Decoder

This block sits in a host-to-PCI bridge and decides, for each processor I/O cycle, one of three outcomes: the cycle targets one of the bridge's own ports, the bridge claims it and forwards it to PCI, or the bridge stays off the cycle. For inbound PCI I/O cycles it decides separately whether the cycle goes up to the host bus. The decode is combinational. The only storage is the 32-bit configuration-address register, which the decoder needs because its top bit gates the configuration-data port.

The bridge runs in one of two roles. A compatibility bridge is the default I/O responder and claims everything. Its enabled windows mark space that belongs to the other bridge. An auxiliary bridge claims only what falls inside its enabled windows. An optional ISA alias fold maps the expansion-board aliases of 100h–3FFh back into that range before the windows are compared.

The decision is held in an enumerated value with four names: `DEC_NONE` (no valid host cycle), `DEC_INTERNAL` (own-port hit), `DEC_FORWARD` (claim and send to PCI) and `DEC_IGNORE` (no claim). The decision is re-evaluated every cycle. There are no transitions between decisions. The configuration-address register moves from its reset value of zero to a new value only on a host write that hits it.

Top module: `io_claim_decoder`

## Requirements
- R1: A host cycle with address 0CF8h and byte enables 1111b raises `hit_cfg_addr` in both roles. Any other byte-enable pattern at 0CF8h is decoded as ordinary I/O.
- R2: `cfg_addr` resets to zero. It loads `host_wdata` on the clock edge that follows a host write which raises `hit_cfg_addr`, and no other write changes it. Bit 31 is the configuration-space enable.
- R3: A host cycle at 0CFCh raises `hit_cfg_data` only while `cfg_addr[31]` is 1. Otherwise it is decoded as ordinary I/O.
- R4: Address 0CF9h raises `hit_reset` only when `role_aux` is 0, whatever the windows hold. With `role_aux` 1 it is decoded as ordinary I/O.
- R5: Window i, where `rng_base`/`rng_limit` bits [16i+15:16i] hold its bounds, matches when `rng_en[i]` is 1 and base <= address <= limit. A window with its enable bit clear never matches.
- R6: When `alias_en` is 1 and the host address has bits [15:10] nonzero and bits [9:8] nonzero, the windows are compared against {6'b0, address[9:0]}. Otherwise the windows see the address unchanged.
- R7: In the compatibility role (`role_aux` 0), an ordinary host cycle raises `host_forward` unless it matches a window, and then it raises `host_ignore`.
- R8: In the auxiliary role (`role_aux` 1), an ordinary host cycle raises `host_forward` only when it matches a window. Otherwise it raises `host_ignore`.
- R9: `pci_to_host` is 1 only when `pci_valid` is 1 and `pci_addr[31:16]` is zero. Under those conditions it is 1 when an auxiliary bridge sees no window match, or when a compatibility bridge sees a window match. PCI addresses are not alias-folded.
- R10: While `host_valid` is 1, exactly one of `host_internal`, `host_forward` and `host_ignore` is 1, and `host_internal` is 1 exactly when one of the three hit flags is. While `host_valid` is 0, all six host outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_aux | input | 1 | 1 = auxiliary role, 0 = compatibility role |
| alias_en | input | 1 | Enables ISA alias folding of host addresses |
| rng_en | input | 2 | Per-window enable |
| rng_base | input | 32 | Window lower bounds, 16 bits each |
| rng_limit | input | 32 | Window upper bounds, 16 bits each |
| host_valid | input | 1 | Host I/O cycle present |
| host_write | input | 1 | Host cycle is a write |
| host_addr | input | 16 | Host I/O byte address |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| pci_valid | input | 1 | Inbound PCI I/O cycle present |
| pci_addr | input | 32 | Inbound PCI I/O address |
| cfg_addr | output | 32 | Configuration-address register contents |
| hit_cfg_addr | output | 1 | Host cycle hits the configuration-address port |
| hit_cfg_data | output | 1 | Host cycle hits the configuration-data port |
| hit_reset | output | 1 | Host cycle hits the reset-control port |
| host_internal | output | 1 | Host cycle targets an own port |
| host_forward | output | 1 | Host cycle claimed and forwarded to PCI |
| host_ignore | output | 1 | Host cycle not claimed |
| pci_to_host | output | 1 | Inbound PCI cycle passed to the host bus |

## Verification
Several properties are checked on every clock cycle by assertions:
- the one-hot outcome, and silence while no host cycle is valid;
- `hit_reset` appearing only in the compatibility role;
- `hit_cfg_data` appearing only while the enable bit is set;
- the 64 KB limit on upward forwarding;
- the register load;
- a disabled window never matching.

Whether each address lands in the right outcome can only be shown by the bench. This includes the window boundaries, the alias fold, the byte-enable rule at 0CF8h, and the precedence of own ports over windows. The bench shows this by sweeping the whole host address space and a large part of the PCI space under each role and alias setting.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

    typedef enum logic [1:0] {
        DEC_NONE     = 2'd0,
        DEC_INTERNAL = 2'd1,
        DEC_FORWARD  = 2'd2,
        DEC_IGNORE   = 2'd3
    } dec_e;

    localparam logic [15:0] PORT_CFG_ADDR = 16'h0CF8;
    localparam logic [15:0] PORT_RESET    = 16'h0CF9;
    localparam logic [15:0] PORT_CFG_DATA = 16'h0CFC;

endpackage

// File: rtl/io_alias_map.sv
module io_alias_map #(
    parameter int AW  = 16,
    parameter int WIN = 10
) (
    input  logic          en,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    logic expansion;

    always_comb begin
        expansion = (|addr_in[AW-1:WIN]) && (|addr_in[WIN-1:WIN-2]);
        if (en && expansion)
            addr_out = {{(AW-WIN){1'b0}}, addr_in[WIN-1:0]};
        else
            addr_out = addr_in;
    end
endmodule

// File: rtl/io_range_match.sv
module io_range_match #(
    parameter int AW = 16,
    parameter int NR = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic [NR-1:0]  win_en,
    input  logic [NR*AW-1:0] win_lo,
    input  logic [NR*AW-1:0] win_hi,
    output logic           match
);
    logic [NR-1:0] hit;

    for (genvar i = 0; i < NR; i++) begin : g_win
        assign hit[i] = win_en[i] &&
                        (addr >= win_lo[i*AW +: AW]) &&
                        (addr <= win_hi[i*AW +: AW]);
    end

    assign match = |hit;

    // R5: with every window disabled nothing can match
    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en == '0) |-> !match);
endmodule

// File: rtl/io_cfg_addr_reg.sv
module io_cfg_addr_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/io_claim_decoder.sv
module io_claim_decoder
    import io_dec_pkg::*;
#(
    parameter int AW  = 16,
    parameter int NR  = 2,
    parameter int DW  = 32,
    parameter int PAW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             role_aux,
    input  logic             alias_en,
    input  logic [NR-1:0]    rng_en,
    input  logic [NR*AW-1:0] rng_base,
    input  logic [NR*AW-1:0] rng_limit,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW/8-1:0]  host_be,
    input  logic [DW-1:0]    host_wdata,
    input  logic             pci_valid,
    input  logic [PAW-1:0]   pci_addr,
    output logic [DW-1:0]    cfg_addr,
    output logic             hit_cfg_addr,
    output logic             hit_cfg_data,
    output logic             hit_reset,
    output logic             host_internal,
    output logic             host_forward,
    output logic             host_ignore,
    output logic             pci_to_host
);
    localparam int BEW = DW / 8;

    dec_e          dec;
    logic [AW-1:0] host_folded;
    logic          host_in_win;
    logic          pci_in_win;
    logic          pci_above;
    logic          sel_cfg_addr, sel_cfg_data, sel_reset;
    logic          cfg_wr;

    io_alias_map #(.AW(AW), .WIN(10)) u_alias (
        .en(alias_en), .addr_in(host_addr), .addr_out(host_folded)
    );

    io_range_match #(.AW(AW), .NR(NR)) u_host_win (
        .clk(clk), .rst_n(rst_n), .addr(host_folded),
        .win_en(rng_en), .win_lo(rng_base), .win_hi(rng_limit), .match(host_in_win)
    );

    io_range_match #(.AW(AW), .NR(NR)) u_pci_win (
        .clk(clk), .rst_n(rst_n), .addr(pci_addr[AW-1:0]),
        .win_en(rng_en), .win_lo(rng_base), .win_hi(rng_limit), .match(pci_in_win)
    );

    io_cfg_addr_reg #(.DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(host_wdata), .q(cfg_addr)
    );

    // own-port selection
    always_comb begin
        sel_cfg_addr = (host_addr == PORT_CFG_ADDR) && (host_be == {BEW{1'b1}});
        sel_cfg_data = (host_addr == PORT_CFG_DATA) && cfg_addr[DW-1];
        sel_reset    = (host_addr == PORT_RESET) && !role_aux;
    end

    // decision
    always_comb begin
        if (!host_valid)
            dec = DEC_NONE;
        else if (sel_cfg_addr || sel_cfg_data || sel_reset)
            dec = DEC_INTERNAL;
        else if (role_aux ? host_in_win : !host_in_win)
            dec = DEC_FORWARD;
        else
            dec = DEC_IGNORE;
    end

    // outputs
    always_comb begin
        hit_cfg_addr  = 1'b0;
        hit_cfg_data  = 1'b0;
        hit_reset     = 1'b0;
        host_internal = 1'b0;
        host_forward  = 1'b0;
        host_ignore   = 1'b0;
        unique case (dec)
            DEC_NONE: ;
            DEC_INTERNAL: begin
                host_internal = 1'b1;
                hit_cfg_addr  = sel_cfg_addr;
                hit_cfg_data  = sel_cfg_data;
                hit_reset     = sel_reset;
            end
            DEC_FORWARD: host_forward = 1'b1;
            DEC_IGNORE:  host_ignore  = 1'b1;
            default: ;
        endcase
    end

    assign cfg_wr = hit_cfg_addr && host_write;

    assign pci_above   = |pci_addr[PAW-1:AW];
    assign pci_to_host = pci_valid && !pci_above && (role_aux ? !pci_in_win : pci_in_win);

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> ($countones({host_internal, host_forward, host_ignore}) == 1));

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |-> !(host_internal || host_forward || host_ignore ||
                          hit_cfg_addr || hit_cfg_data || hit_reset));

    assert_reset_role_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_reset |-> !role_aux);

    assert_data_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cfg_data |-> cfg_addr[DW-1]);

    assert_pci_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pci_to_host |-> (pci_valid && (pci_addr[PAW-1:AW] == '0)));
endmodule

// File: tb/io_claim_decoder_test.sv
`timescale 1ns/1ps
module io_claim_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        role_aux = 1'b0, alias_en = 1'b0;
    logic [1:0]  rng_en = 2'b00;
    logic [15:0] b0 = 16'h0100, l0 = 16'h01FF, b1 = 16'h0CF0, l1 = 16'h0D0F;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [15:0] host_addr = '0;
    logic [3:0]  host_be = 4'hF;
    logic [31:0] host_wdata = '0;
    logic        pci_valid = 1'b0;
    logic [31:0] pci_addr = '0;
    logic [31:0] cfg_addr;
    logic hit_cfg_addr, hit_cfg_data, hit_reset, host_internal, host_forward, host_ignore, pci_to_host;

    int checks = 0, errors = 0;
    logic [31:0] model_cfg = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    io_claim_decoder uut (
        .clk(clk), .rst_n(rst_n), .role_aux(role_aux), .alias_en(alias_en),
        .rng_en(rng_en), .rng_base({b1, b0}), .rng_limit({l1, l0}),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .host_be(host_be), .host_wdata(host_wdata), .pci_valid(pci_valid),
        .pci_addr(pci_addr), .cfg_addr(cfg_addr), .hit_cfg_addr(hit_cfg_addr),
        .hit_cfg_data(hit_cfg_data), .hit_reset(hit_reset), .host_internal(host_internal),
        .host_forward(host_forward), .host_ignore(host_ignore), .pci_to_host(pci_to_host)
    );

    function automatic logic in_win(input logic [15:0] a);
        return (rng_en[0] && a >= b0 && a <= l0) || (rng_en[1] && a >= b1 && a <= l1);
    endfunction

    function automatic logic [5:0] expect_host();
        logic [15:0] m;
        logic ca, cd, rs, fw;
        if (!host_valid) return 6'b0;
        ca = (host_addr == 16'h0CF8) && (host_be == 4'hF);
        cd = (host_addr == 16'h0CFC) && model_cfg[31];
        rs = (host_addr == 16'h0CF9) && !role_aux;
        if (ca || cd || rs) return {ca, cd, rs, 3'b100};
        m = (alias_en && host_addr[15:10] != 0 && host_addr[9:8] != 0) ?
            {6'b0, host_addr[9:0]} : host_addr;
        fw = role_aux ? in_win(m) : !in_win(m);
        return {3'b000, 1'b0, fw, !fw};
    endfunction

    task automatic check_host(input string tag);
        logic [5:0] got, exp;
        got = {hit_cfg_addr, hit_cfg_data, hit_reset, host_internal, host_forward, host_ignore};
        exp = expect_host();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h be=%b aux=%b alias=%b actual=%b expected=%b",
                     tag, host_addr, host_be, role_aux, alias_en, got, exp);
        end
    endtask

    task automatic check_pci(input string tag);
        logic exp;
        exp = pci_valid && (pci_addr[31:16] == 0) &&
              (role_aux ? !in_win(pci_addr[15:0]) : in_win(pci_addr[15:0]));
        checks++;
        if (pci_to_host !== exp) begin
            errors++;
            $display("FAIL %s pci_addr=%h aux=%b actual=%b expected=%b",
                     tag, pci_addr, role_aux, pci_to_host, exp);
        end
    endtask

    task automatic check_cfg(input string tag);
        checks++;
        if (cfg_addr !== model_cfg) begin
            errors++;
            $display("FAIL %s cfg_addr actual=%h expected=%h", tag, cfg_addr, model_cfg);
        end
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        host_valid = 1; host_write = 1; host_addr = a; host_be = be; host_wdata = d;
        @(posedge clk);
        #1;
        if (a == 16'h0CF8 && be == 4'hF) model_cfg = d;
        host_write = 0; host_valid = 0;
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
    end

    initial begin
        #12 rst_n = 1'b1;
        @(negedge clk);
        check_cfg("R2 reset value");
        // R10: idle host cycle gives no outputs
        host_addr = 16'h0CF8; #1 check_host("R10 idle");
        rng_en = 2'b11;
        host_valid = 1;
        // R1, R5, R6, R7, R8, R4: full sweep of host space per role and alias setting
        for (int r = 0; r < 2; r++) begin
            for (int al = 0; al < 2; al++) begin
                role_aux = r[0]; alias_en = al[0];
                for (int a = 0; a < 65536; a++) begin
                    host_addr = a[15:0]; #1;
                    check_host("R7 R8 sweep");
                end
            end
        end
        // R1: partial byte enables at 0CF8h decode as ordinary I/O
        for (int r = 0; r < 2; r++) begin
            for (int be = 0; be < 16; be++) begin
                role_aux = r[0]; host_addr = 16'h0CF8; host_be = be[3:0]; #1;
                check_host("R1 byte enables");
            end
        end
        host_be = 4'hF;
        // R5: disabled windows
        rng_en = 2'b01; role_aux = 1;
        for (int a = 16'h0CE0; a < 16'h0D20; a++) begin
            host_addr = a[15:0]; #1; check_host("R5 window off");
        end
        rng_en = 2'b11;
        // R2, R3: enable bit controls the data port
        host_wr(16'h0CF8, 4'h7, 32'h8000_1234); check_cfg("R2 partial write ignored");
        host_valid = 1; host_addr = 16'h0CFC; #1; check_host("R3 disabled");
        host_wr(16'h0CF8, 4'hF, 32'h8000_ABCD); check_cfg("R2 load");
        host_valid = 1;
        for (int r = 0; r < 2; r++) begin
            role_aux = r[0]; host_addr = 16'h0CFC; #1; check_host("R3 enabled");
        end
        host_wr(16'h0CFC, 4'hF, 32'h0000_0000); check_cfg("R2 data port write");
        host_wr(16'h0CF8, 4'hF, 32'h7FFF_FFFF); check_cfg("R2 clear enable");
        host_valid = 1; host_addr = 16'h0CFC; #1; check_host("R3 cleared");
        host_valid = 0; #1; check_host("R10 idle after");
        // R9: inbound PCI
        pci_valid = 0; pci_addr = 32'h0000_0150; #1; check_pci("R9 idle");
        pci_valid = 1;
        for (int r = 0; r < 2; r++) begin
            role_aux = r[0];
            for (int a = 0; a < 65536; a += 3) begin
                pci_addr = {16'h0000, a[15:0]}; #1; check_pci("R9 low");
                pci_addr = {16'h0001, a[15:0]}; #1; check_pci("R9 above 64K");
            end
            pci_addr = 32'h0000_0D0F; #1; check_pci("R9 limit edge");
            pci_addr = 32'h0000_0D10; #1; check_pci("R9 past limit");
            pci_addr = 32'h0000_0500; #1; check_pci("R9 no fold");
        end
        done = 1;
    end

    initial begin
        wait (done);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule